// File: doc/BRIEF.md
# Serial Receive Character Error and Line Break Detector

This block sits right after a serial receive deserializer. For each completed character it gets the data bits, the parity sample and the stop-bit sample. It classifies the character and passes it on, one cycle later, with three status bits:

- framing error
- parity error
- received break

These bits belong to that character alone and travel with it to whatever buffer follows.

The block also follows the line break state. A character whose data, enabled parity sample and stop sample are all zero opens a break. While the break lasts, further character strobes are dropped. The break closes only after the raw receive line has been sampled high on a set number of successive 1x bit-clock enables (two by default); a low sample in between restarts that count. Both the opening and the closing of a break raise a sticky change-of-break flag. The reset-error command clears that flag.

Top module: `uart_rx_errchk`

## Requirements
- R1: After reset, `out_valid`, `out_fe`, `out_pe`, `out_rb` and `brk_chg` are 0.
- R2: A `char_done` pulse accepted outside a break makes `out_valid` high for exactly the next cycle. In that cycle `out_data` equals the strobed data bits.
- R3: The framing bit is 1 exactly when `stop_bit` is 0 and the character is not all-zero. "Character" here means the data bits plus the parity sample when parity is enabled.
- R4: `par_mode` encoding is 2'b01 even, 2'b10 odd, and 2'b00 or 2'b11 none. In even mode the parity bit is 1 when the XOR of the data bits plus `par_bit` is 1. In odd mode it is 1 when that XOR is 0. It is always 0 for a break character.
- R5: With no parity (`par_mode` 2'b00 or 2'b11), `out_pe` stays 0 and `par_bit` plays no part in any result.
- R6: A character that is all zero (data, enabled parity sample, stop sample) is passed on with `out_rb`=1 and `out_fe`=0. It also starts a break and sets `brk_chg`.
- R7: While a break is active, `char_done` pulses produce no `out_valid`.
- R8: A break ends on the `END_TICKS`-th successive `bit_tick` that finds `rxd` high. A `bit_tick` with `rxd` low restarts the count. Ticks taken outside a break have no effect.
- R9: The end of a break sets `brk_chg` without producing any character or `out_rb`.
- R10: `err_clr` clears `brk_chg` on the next edge. If a break starts or ends in the same cycle, `brk_chg` is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_done | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | DATA_W | Received data bits |
| par_bit | input | 1 | Received parity sample |
| stop_bit | input | 1 | Received stop-bit sample |
| par_mode | input | 2 | Parity mode: 01 even, 10 odd, 00/11 none |
| rxd | input | 1 | Raw receive line level |
| bit_tick | input | 1 | 1x bit-clock enable |
| err_clr | input | 1 | Reset-error command, clears change-of-break |
| out_valid | output | 1 | Character with status is presented |
| out_data | output | DATA_W | Presented character |
| out_fe | output | 1 | Framing error of presented character |
| out_pe | output | 1 | Parity error of presented character |
| out_rb | output | 1 | Received-break bit of presented character |
| brk_chg | output | 1 | Sticky change-of-break flag |

## Verification
The reset-error command and a break transition can land on the same clock edge. That transition is either a break-opening character or the closing high tick. The bench drives `err_clr` together with the all-zero character strobe, and later together with the final high `bit_tick`. In both cases it expects `brk_chg` to read 1 afterwards. A lone `err_clr` must drop the flag to 0, which shows that the set really won rather than the clear being ignored.

// File: rtl/uart_rxerr_pkg.sv
package uart_rxerr_pkg;
  typedef enum logic [1:0] {
    PAR_NONE0 = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_NONE3 = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic fe;
    logic pe;
    logic rb;
  } char_stat_t;
endpackage

// File: rtl/rxerr_classify.sv
module rxerr_classify
  import uart_rxerr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par_bit,
  input  logic              stop_bit,
  input  logic [1:0]        par_mode,
  output logic              is_break,
  output char_stat_t        stat
);
  logic par_en;
  logic par_used;
  logic char_zero;
  logic par_expect;

  always_comb begin
    par_en     = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    par_used   = par_en & par_bit;
    char_zero  = (data == '0) && !par_used;
    par_expect = (par_mode == PAR_EVEN) ? (^data) : ~(^data);
    is_break   = char_zero && !stop_bit;
    stat.rb    = is_break;
    stat.fe    = !stop_bit && !char_zero;
    stat.pe    = par_en && !is_break && (par_bit != par_expect);
  end

  // R3
  fe_rb_excl_chk: assert final (!(stat.fe && stat.rb));
  // R5
  no_par_quiet_chk: assert final (par_en || !stat.pe);
endmodule

// File: rtl/rxerr_brk_trk.sv
module rxerr_brk_trk #(
  parameter int END_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_start,
  input  logic rxd,
  input  logic bit_tick,
  output logic brk_active,
  output logic brk_end
);
  localparam int CNT_W = $clog2(END_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(END_TICKS - 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d   = act_q;
    cnt_d   = cnt_q;
    brk_end = 1'b0;
    if (!act_q) begin
      cnt_d = '0;
      if (brk_start) act_d = 1'b1;
    end else if (bit_tick) begin
      if (!rxd) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        act_d   = 1'b0;
        cnt_d   = '0;
        brk_end = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign brk_active = act_q;

  // R8
  brk_end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(rxd) && $past(bit_tick));
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rxerr_chg_flag.sv
module rxerr_chg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_cmd,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_ev)       flag_d = 1'b1;
    else if (clr_cmd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R10
  clr_wins_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd && !set_ev |=> !flag_q);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);
endmodule

// File: rtl/uart_rx_errchk.sv
module uart_rx_errchk
  import uart_rxerr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int END_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              par_bit,
  input  logic              stop_bit,
  input  logic [1:0]        par_mode,
  input  logic              rxd,
  input  logic              bit_tick,
  input  logic              err_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fe,
  output logic              out_pe,
  output logic              out_rb,
  output logic              brk_chg
);
  logic       is_break;
  char_stat_t stat;
  logic       brk_active;
  logic       brk_end;
  logic       accept;
  logic       brk_start;

  rxerr_classify #(.DATA_W(DATA_W)) u_cls (
    .data     (char_data),
    .par_bit  (par_bit),
    .stop_bit (stop_bit),
    .par_mode (par_mode),
    .is_break (is_break),
    .stat     (stat)
  );

  assign accept    = char_done && !brk_active;
  assign brk_start = accept && is_break;

  rxerr_brk_trk #(.END_TICKS(END_TICKS)) u_brk (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_start  (brk_start),
    .rxd        (rxd),
    .bit_tick   (bit_tick),
    .brk_active (brk_active),
    .brk_end    (brk_end)
  );

  rxerr_chg_flag u_chg (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (brk_start || brk_end),
    .clr_cmd (err_clr),
    .flag    (brk_chg)
  );

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  char_stat_t        st_q, st_d;

  always_comb begin
    vld_d = accept;
    dat_d = dat_q;
    st_d  = '0;
    if (accept) begin
      dat_d = char_data;
      st_d  = stat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      st_q  <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      st_q  <= st_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_fe    = st_q.fe;
  assign out_pe    = st_q.pe;
  assign out_rb    = st_q.rb;

  // R7
  no_char_in_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active && char_done |=> !out_valid);
  // R6
  brk_open_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_active) |-> brk_chg && out_rb && out_valid);
  // R9
  brk_close_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active) |-> brk_chg && !out_valid);
  // R2
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_fe || out_pe || out_rb));
endmodule

// File: tb/sim_uart_rx_errchk.sv
`timescale 1ns/1ps
module sim_uart_rx_errchk;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          char_done, par_bit, stop_bit, rxd, bit_tick, err_clr;
  logic [DW-1:0] char_data;
  logic [1:0]    par_mode;
  logic          out_valid, out_fe, out_pe, out_rb, brk_chg;
  logic [DW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  uart_rx_errchk #(.DATA_W(DW), .END_TICKS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
    .par_bit(par_bit), .stop_bit(stop_bit), .par_mode(par_mode), .rxd(rxd),
    .bit_tick(bit_tick), .err_clr(err_clr), .out_valid(out_valid),
    .out_data(out_data), .out_fe(out_fe), .out_pe(out_pe), .out_rb(out_rb),
    .brk_chg(brk_chg)
  );

  function automatic bit par_on(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic bit exp_brk(input logic [DW-1:0] d, input bit p, input bit s,
                                 input logic [1:0] m);
    return (d == 0) && !(par_on(m) && p) && !s;
  endfunction

  function automatic bit exp_fe(input logic [DW-1:0] d, input bit p, input bit s,
                                input logic [1:0] m);
    return !s && !((d == 0) && !(par_on(m) && p));
  endfunction

  function automatic bit exp_pe(input logic [DW-1:0] d, input bit p, input bit s,
                                input logic [1:0] m);
    bit ones;
    ones = ^{d, p};
    if (!par_on(m) || exp_brk(d, p, s, m)) return 1'b0;
    return (m == 2'b01) ? ones : !ones;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strobe one character; sample at the following negedge (one register stage).
  task automatic send(input logic [DW-1:0] d, input bit p, input bit s,
                      input logic [1:0] m, input bit clr, input bit in_brk);
    @(negedge clk);
    char_data = d; par_bit = p; stop_bit = s; par_mode = m;
    char_done = 1'b1; err_clr = clr;
    @(negedge clk);
    char_done = 1'b0; err_clr = 1'b0;
    if (in_brk) begin
      chk("R7 valid during break", out_valid, 0);
    end else begin
      chk("R2 valid", out_valid, 1);
      chk("R2 data", out_data, d);
      chk("R3 fe", out_fe, exp_fe(d, p, s, m));
      chk("R4 pe", out_pe, exp_pe(d, p, s, m));
      chk("R6 rb", out_rb, exp_brk(d, p, s, m));
    end
  endtask

  task automatic tick(input bit lvl, input bit clr);
    @(negedge clk);
    rxd = lvl; bit_tick = 1'b1; err_clr = clr;
    @(negedge clk);
    bit_tick = 1'b0; err_clr = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 17;
    void'($urandom(seed));
    rst_n = 1'b0; char_done = 0; char_data = 0; par_bit = 0; stop_bit = 1;
    par_mode = 0; rxd = 1; bit_tick = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 valid", out_valid, 0);
    chk("R1 flags", {out_fe, out_pe, out_rb}, 0);
    chk("R1 brk_chg", brk_chg, 0);

    // R8: ticks outside a break change nothing
    tick(1, 0); tick(1, 0);
    chk("R8 idle ticks", brk_chg, 0);

    // Random characters, breaks avoided
    for (int i = 0; i < 300; i++) begin
      logic [DW-1:0] d;
      bit p, s;
      logic [1:0] m;
      d = DW'($urandom);
      p = 1'($urandom);
      s = ($urandom % 4) != 0;
      m = 2'($urandom);
      if (exp_brk(d, p, s, m)) s = 1'b1;
      send(d, p, s, m, 0, 0);
    end
    chk("R9 no change after random", brk_chg, 0);

    // R3: zero data with parity sample 1 is not a break
    send(8'h00, 1, 0, 2'b01, 0, 0);
    // R5: no parity, parity sample ignored
    send(8'h07, 1, 1, 2'b11, 0, 0);
    send(8'h07, 0, 1, 2'b00, 0, 0);

    // R6: break start with even parity
    send(8'h00, 0, 0, 2'b01, 0, 0);
    chk("R6 brk_chg set", brk_chg, 1);
    clear();
    chk("R10 clear", brk_chg, 0);
    // R7: characters ignored during break
    send(8'h5A, 1, 1, 2'b10, 0, 1);
    // R8: high, low, high does not end
    tick(1, 0); tick(0, 0); tick(1, 0);
    chk("R8 interrupted high", brk_chg, 0);
    send(8'h11, 0, 1, 2'b00, 0, 1);
    tick(1, 0);
    chk("R9 end sets chg", brk_chg, 1);
    chk("R9 no char at end", out_valid, 0);
    send(8'h33, 0, 1, 2'b01, 0, 0);
    clear();

    // R10 collision: clear with break start
    send(8'h00, 1, 0, 2'b00, 1, 0);
    chk("R10 set beats clear at start", brk_chg, 1);
    clear();
    chk("R10 clear alone", brk_chg, 0);
    tick(1, 0);
    tick(1, 1);
    chk("R10 set beats clear at end", brk_chg, 1);
    send(8'h80, 1, 0, 2'b10, 0, 0);
    clear();
    chk("R10 final clear", brk_chg, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule